// File: doc/BRIEF.md
# Conditional IF Stack Sequencer

This block owns the program counter of a shader sequencer and implements structured conditional execution. When an instruction retires (`step_i`), the counter normally advances by one. A conditional-if instruction compares two condition flags against two reference bits, one comparison per lane. A 2-bit mode then merges the two lane results into one decision.

A true decision stores an (else-address, else-length) pair on a small stack, and execution falls through into the if-body. A false decision loads the counter with the else-address. After every counter update, the block checks the updated value against the else-address of the top stack entry. On a match it advances the counter past the else-body by the stored length and drops the entry. A start pulse begins a new invocation: it loads the entry address, empties the stack and fills every entry with all ones.

Top module: `if_stack_seq`

## Requirements
- R1: After reset, `pc_o` is 0, `depth_o` is 0 and `overflow_o` is 0.
- R2: `start_i` loads `pc_o` with `start_pc_i`, sets `depth_o` to 0 and clears `overflow_o` on the next edge. It takes priority over `step_i`.
- R3: A retired instruction that is not a conditional-if advances `pc_o` by 1, modulo 2^ADDR_W.
- R4: Lane x is true when `ref_i[0]` equals `cc_i[0]`. Lane y is true when `ref_i[1]` equals `cc_i[1]`.
- R5: `mode_i` merges the lanes as follows: 0 gives x OR y, 1 gives x AND y, 2 gives x alone, 3 gives y alone.
- R6: A true conditional-if pushes (`dest_i`, `count_i`), advances `pc_o` by 1 and raises `depth_o` by 1.
- R7: A false conditional-if loads `pc_o` with `dest_i` and pushes nothing.
- R8: After the counter update in the same cycle, the block compares the updated value with the top entry's else-address. The top entry may be the one pushed in that cycle. If the stack is non-empty and the two match, `pc_o` becomes the updated value plus the entry's length, and the entry is popped.
- R9: Entries are matched and popped last-in first-out, so nested bodies close innermost first.
- R10: With DEPTH entries held, a true conditional-if discards its entry and sets `overflow_o`. `overflow_o` stays set until the next start.
- R11: When `step_i` is low, the conditional-if inputs have no effect: `pc_o`, `depth_o` and `overflow_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new invocation |
| start_pc_i | input | ADDR_W | Entry address loaded at start |
| step_i | input | 1 | One instruction retires this cycle |
| ifc_i | input | 1 | Retiring instruction is a conditional-if |
| cc_i | input | 2 | Condition flags (bit 0 lane x, bit 1 lane y) |
| ref_i | input | 2 | Reference bits (bit 0 lane x, bit 1 lane y) |
| mode_i | input | 2 | Lane merge mode |
| dest_i | input | ADDR_W | Else-address of the conditional-if |
| count_i | input | CNT_W | Else-body length |
| pc_o | output | ADDR_W | Program counter |
| depth_o | output | $clog2(DEPTH+1) | Stack entries held |
| overflow_o | output | 1 | Sticky stack overflow |

## Verification
Every result of a step appears exactly one clock edge after the step: the jump, the push and the same-cycle skip with its pop. This holds because the skip compare works on the combinational next counter and not on the registered one. The bench drives each stimulus just after a falling edge and lets one rising edge pass. It then samples `pc_o`, `depth_o` and `overflow_o` at the following falling edge. Cases with no effect, such as a stalled conditional-if, are checked with the same one-edge timing.

// File: rtl/ifc_seq_pkg.sv
package ifc_seq_pkg;
  typedef enum logic [1:0] {
    CMB_OR  = 2'd0,
    CMB_AND = 2'd1,
    CMB_X   = 2'd2,
    CMB_Y   = 2'd3
  } cmb_mode_e;
endpackage

// File: rtl/ifc_cond_eval.sv
module ifc_cond_eval
  import ifc_seq_pkg::*;
(
  input  logic [1:0] cc_i,
  input  logic [1:0] ref_i,
  input  logic [1:0] mode_i,
  output logic       take_o
);
  logic lane_x, lane_y;

  assign lane_x = (ref_i[0] == cc_i[0]);
  assign lane_y = (ref_i[1] == cc_i[1]);

  always_comb begin
    unique case (cmb_mode_e'(mode_i))
      CMB_OR:  take_o = lane_x | lane_y;
      CMB_AND: take_o = lane_x & lane_y;
      CMB_X:   take_o = lane_x;
      default: take_o = lane_y;
    endcase
  end

  // R5: a taken AND needs both lanes to match
  always_comb begin
    if (mode_i == 2'd1 && take_o)
      assert (ref_i == cc_i) else $error("p_and_both_r5");
  end
endmodule

// File: rtl/ifc_stack.sv
module ifc_stack #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] top_addr_o,
  output logic [CNT_W-1:0]  top_cnt_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [PW-1:0]     depth_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q  [DEPTH];
  logic [PW-1:0]     sp_q;
  logic [IW-1:0]     top_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[i] <= '1;
        cnt_q[i]  <= '1;
      end else if (clear_i) begin
        addr_q[i] <= '1;
        cnt_q[i]  <= '1;
      end else if (push_i && sp_q == PW'(i)) begin
        addr_q[i] <= addr_i;
        cnt_q[i]  <= cnt_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sp_q <= '0;
    else if (clear_i)           sp_q <= '0;
    else if (push_i && !pop_i)  sp_q <= sp_q + 1'b1;
    else if (pop_i && !push_i)  sp_q <= sp_q - 1'b1;
  end

  assign top_idx    = IW'(sp_q - 1'b1);
  assign top_addr_o = addr_q[top_idx];
  assign top_cnt_o  = cnt_q[top_idx];
  assign empty_o    = (sp_q == '0);
  assign full_o     = (sp_q == PW'(DEPTH));
  assign depth_o    = sp_q;

  p_push_room_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clear_i |-> !full_o);
  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !clear_i |-> !empty_o);
  p_depth_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= PW'(DEPTH));
endmodule

// File: rtl/if_stack_seq.sv
module if_stack_seq #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_pc_i,
  input  logic              step_i,
  input  logic              ifc_i,
  input  logic [1:0]        cc_i,
  input  logic [1:0]        ref_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] dest_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [PW-1:0]     depth_o,
  output logic              overflow_o
);
  logic [ADDR_W-1:0] pc_q, seq_pc, pc_d, top_addr, eff_addr;
  logic [CNT_W-1:0]  top_cnt, eff_cnt;
  logic              ovf_q, take, step_v, is_if, if_true, push_ok;
  logic              empty, full, eff_valid, skip;

  ifc_cond_eval u_cond (
    .cc_i   (cc_i),
    .ref_i  (ref_i),
    .mode_i (mode_i),
    .take_o (take)
  );

  assign step_v  = step_i & ~start_i;
  assign is_if   = step_v & ifc_i;
  assign if_true = is_if & take;
  assign push_ok = if_true & ~full;

  // next sequential pc: jump on false condition, else fall through
  assign seq_pc = (is_if && !take) ? dest_i : pc_q + 1'b1;

  // a freshly pushed entry is already the top for the skip compare
  assign eff_valid = push_ok | ~empty;
  assign eff_addr  = push_ok ? dest_i  : top_addr;
  assign eff_cnt   = push_ok ? count_i : top_cnt;
  assign skip      = step_v & eff_valid & (seq_pc == eff_addr);
  assign pc_d      = skip ? seq_pc + ADDR_W'(eff_cnt) : seq_pc;

  ifc_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_i),
    .push_i     (push_ok & ~skip),
    .pop_i      (skip & ~push_ok),
    .addr_i     (dest_i),
    .cnt_i      (count_i),
    .top_addr_o (top_addr),
    .top_cnt_o  (top_cnt),
    .empty_o    (empty),
    .full_o     (full),
    .depth_o    (depth_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
    end else if (start_i) begin
      pc_q  <= start_pc_i;
      ovf_q <= 1'b0;
    end else begin
      if (step_v)          pc_q  <= pc_d;
      if (if_true && full) ovf_q <= 1'b1;
    end
  end

  assign pc_o       = pc_q;
  assign overflow_o = ovf_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pc_o == $past(start_pc_i) && depth_o == '0 && !overflow_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !start_i |=> $stable(pc_o) && $stable(depth_o) && $stable(overflow_o));
  p_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !start_i && ifc_i && !take && depth_o == '0 |=> pc_o == $past(dest_i));
  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !start_i |=> overflow_o);
endmodule

// File: tb/if_stack_seq_tb_top.sv
module if_stack_seq_tb_top;
  localparam int DEPTH = 8;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int PW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, step = 1'b0, ifc = 1'b0;
  logic [AW-1:0] start_pc = '0, dest = '0;
  logic [1:0] cc = '0, rf = '0, mode = '0;
  logic [CW-1:0] cnt = '0;
  logic [AW-1:0] pc;
  logic [PW-1:0] depth;
  logic ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] m_addr [DEPTH];
  logic [CW-1:0] m_cnt [DEPTH];
  int m_sp = 0;
  logic [AW-1:0] m_pc = '0;
  bit m_ovf = 0;

  always #5 clk = ~clk;

  if_stack_seq #(.DEPTH(DEPTH), .ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .start_pc_i(start_pc),
    .step_i(step), .ifc_i(ifc), .cc_i(cc), .ref_i(rf), .mode_i(mode),
    .dest_i(dest), .count_i(cnt), .pc_o(pc), .depth_o(depth), .overflow_o(ovf)
  );

  function automatic bit cond_f(logic [1:0] c, logic [1:0] r, logic [1:0] m);
    bit x = (c[0] == r[0]);
    bit y = (c[1] == r[1]);
    case (m)
      2'd0: return x | y;
      2'd1: return x & y;
      2'd2: return x;
      default: return y;
    endcase
  endfunction

  task automatic check(string tag);
    checks++;
    if (pc !== m_pc || depth !== PW'(m_sp) || ovf !== m_ovf) begin
      errors++;
      $display("FAIL %s: pc=%0d depth=%0d ovf=%0d expected pc=%0d depth=%0d ovf=%0d",
               tag, pc, depth, ovf, m_pc, m_sp, m_ovf);
    end
  endtask

  task automatic do_start(logic [AW-1:0] p, string tag);
    start = 1'b1; start_pc = p; step = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; step = 1'b0;
    m_pc = p; m_sp = 0; m_ovf = 0;
    check(tag);
  endtask

  task automatic do_step(bit st, bit isif, logic [1:0] c, logic [1:0] r, logic [1:0] m,
                         logic [AW-1:0] d, logic [CW-1:0] n, string tag);
    step = st; ifc = isif; cc = c; rf = r; mode = m; dest = d; cnt = n;
    @(posedge clk); @(negedge clk);
    step = 1'b0; ifc = 1'b0;
    if (st) begin
      if (isif && cond_f(c, r, m)) begin
        if (m_sp < DEPTH) begin m_addr[m_sp] = d; m_cnt[m_sp] = n; m_sp++; end
        else m_ovf = 1;
        m_pc = m_pc + 1'b1;
      end else if (isif) m_pc = d;
      else m_pc = m_pc + 1'b1;
      if (m_sp > 0 && m_pc == m_addr[m_sp-1]) begin
        m_pc = m_pc + AW'(m_cnt[m_sp-1]);
        m_sp--;
      end
    end
    check(tag);
  endtask

  task automatic plain(string tag);
    do_step(1, 0, 2'b00, 2'b00, 2'd0, '0, '0, tag);
  endtask

  task automatic t_reset;
    checks++;
    if (pc !== '0 || depth !== '0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1: pc=%0d depth=%0d ovf=%0d expected 0 0 0", pc, depth, ovf);
    end
  endtask

  task automatic t_linear;
    do_start(12'd4094, "R2 start");
    plain("R3 advance");
    plain("R3 wrap");
    plain("R3 after wrap");
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) begin
          do_start(12'd100, "R2 start");
          do_step(1, 1, 2'(c), 2'(r), 2'(m), 12'd50, 8'd3, "R4 R5 R6 R7 lanes/mode");
        end
  endtask

  task automatic t_skip;
    do_start(12'd10, "R2 start");
    do_step(1, 1, 2'b00, 2'b00, 2'd1, 12'd13, 8'd4, "R6 push");
    plain("R3 body");
    plain("R8 skip at else");
    do_start(12'd20, "R2 start");
    do_step(1, 1, 2'b00, 2'b00, 2'd0, 12'd21, 8'd5, "R8 push and skip same cycle");
    do_start(12'd30, "R2 start");
    do_step(1, 1, 2'b11, 2'b11, 2'd2, 12'd40, 8'd2, "R6 outer push");
    do_step(1, 1, 2'b01, 2'b10, 2'd0, 12'd40, 8'd7, "R7 R8 jump then skip");
  endtask

  task automatic t_nested;
    do_start(12'd0, "R2 start");
    do_step(1, 1, 2'b10, 2'b10, 2'd3, 12'd10, 8'd2, "R9 outer push");
    do_step(1, 1, 2'b10, 2'b10, 2'd3, 12'd5, 8'd1, "R9 inner push");
    for (int i = 0; i < 3; i++) plain("R9 inner closes first");
    for (int i = 0; i < 4; i++) plain("R9 outer closes");
  endtask

  task automatic t_overflow;
    do_start(12'd0, "R2 start");
    for (int i = 0; i < DEPTH; i++)
      do_step(1, 1, 2'b00, 2'b00, 2'd0, 12'd200, 8'd1, "R6 fill");
    do_step(1, 1, 2'b00, 2'b00, 2'd0, 12'd300, 8'd1, "R10 push on full");
    plain("R10 overflow sticky");
    do_step(0, 1, 2'b01, 2'b10, 2'd1, 12'd77, 8'd1, "R11 stalled if ignored");
    do_start(12'd3, "R2 start clears overflow");
  endtask

  task automatic t_stall;
    do_step(0, 1, 2'b01, 2'b10, 2'd1, 12'd77, 8'd1, "R11 stalled false if");
    do_step(0, 1, 2'b00, 2'b00, 2'd0, 12'd77, 8'd1, "R11 stalled true if");
    do_step(1, 1, 2'b00, 2'b00, 2'd0, 12'd90, 8'd1, "R6 push");
    start = 1'b1; start_pc = 12'd600; step = 1'b1; ifc = 1'b1; dest = 12'd601;
    @(posedge clk); @(negedge clk);
    start = 1'b0; step = 1'b0; ifc = 1'b0;
    m_pc = 12'd600; m_sp = 0; m_ovf = 0;
    check("R2 start wins over step");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_modes();
    t_skip();
    t_nested();
    t_overflow();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule